// File: doc/BRIEF.md
# Burst column address generator

This block walks the column addresses of one synchronous DRAM burst. A start strobe loads a start column, a burst-length code and a wrap-order bit. From the next clock on, the block presents one column per beat. An advance input steps the burst forward by one beat on each clock where it is high.

For fixed lengths of 2, 4 or 8 beats, the burst stays inside an aligned window whose size is the burst length. Only the low bits move: they move by addition in sequential order, or by an exclusive-or with the beat count in interleaved order. The bits above the window stay unchanged. A full-page burst steps sequentially through the whole row, wraps around at the end, and runs until a stop input ends it.

The block fits inside a memory model, or inside the data-path checker of a memory controller. There it supplies the column that each data beat must belong to. It does not decode commands, store data, or time activate and precharge.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, valid_o and last_o are low and col_o is zero.
- R2: On the clock after start_i is sampled high, valid_o is high and col_o equals the start column that was sampled with it.
- R3: In sequential order with length L in {2,4,8}, beat k shows the start column with its low log2(L) bits replaced by (start + k) mod L. The bits above stay unchanged.
- R4: With wrap_il_i = 1 and length L in {2,4,8}, beat k shows the start column with its low log2(L) bits replaced by (start XOR k). The bits above stay unchanged.
- R5: blen_i selects the length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. The codes 4, 5 and 6 act as a 1-beat burst.
- R6: For fixed lengths, last_o is high exactly on beat L-1. If adv_i is high on that beat, valid_o is low on the next clock.
- R7: While a burst is active and adv_i is low (with no start and no stop), col_o, valid_o and last_o hold their values.
- R8: A full-page burst shows (start + k) mod 2^COL_W on beat k, wraps from the last column to zero, and never raises last_o. wrap_il_i has no effect on it.
- R9: stop_i high during an active burst makes valid_o low on the next clock. When start_i is also high in the same cycle, the start wins.
- R10: A start strobe during an active burst discards that burst and begins the new one on the next clock.
- R11: With no burst active and start_i low, adv_i and stop_i leave valid_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Loads a new burst, overriding any burst in progress |
| start_col_i | input | COL_W | First column of the burst |
| blen_i | input | 3 | Burst-length code (see R5) |
| wrap_il_i | input | 1 | 1 selects interleaved order, 0 selects sequential |
| adv_i | input | 1 | Step to the next beat on this clock |
| stop_i | input | 1 | End the current burst |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | The current beat is the final beat of a fixed-length burst |

## Verification
The bench sweeps every length code and both orders over start columns spread across all low-bit phases. This catches a carry that leaks above the window in sequential order, or an interleave that adds instead of XORing; either would put a beat outside the aligned window. It also looks for a last flag one beat early or late, and for reserved codes that do not behave as single beats. Long full-page runs starting near the top of the row show whether the wrap to column zero happens, and whether a stray last flag or an honoured interleave bit corrupts page mode. Directed cases check stop against start priority, a restart in mid-burst, a held advance, and stimulus while idle. A design that got these wrong would keep stale beats, end a burst late, or start one from nothing.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    // Burst-length codes seen on blen_i
    typedef enum logic [2:0] {
        BL_ONE  = 3'd0,
        BL_TWO  = 3'd1,
        BL_FOUR = 3'd2,
        BL_EIGHT = 3'd3,
        BL_PAGE = 3'd7
    } blen_code_e;

    localparam int BLEN_CODE_W = 3;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [BLEN_CODE_W-1:0] code_i,
    output logic [COL_W-1:0]       mask_o,
    output logic                   page_o
);

    // The mask marks the column bits that move inside the burst window
    always_comb begin
        page_o = 1'b0;
        mask_o = '0;
        case (code_i)
            BL_TWO:   mask_o = COL_W'(1);
            BL_FOUR:  mask_o = COL_W'(3);
            BL_EIGHT: mask_o = COL_W'(7);
            BL_PAGE: begin
                mask_o = '1;
                page_o = 1'b1;
            end
            default:  mask_o = '0;
        endcase
    end

endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             il_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] seq_sum;
    logic [COL_W-1:0] il_mix;

    assign seq_sum = base_i + cnt_i;
    assign il_mix  = base_i ^ cnt_i;

    // Bits inside the window take the moving value; bits above keep the base
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = mask_i[b] ? (il_i ? il_mix[b] : seq_sum[b]) : base_i[b];
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [COL_W-1:0]       start_col_i,
    input  logic [BLEN_CODE_W-1:0] blen_i,
    input  logic                   wrap_il_i,
    input  logic                   adv_i,
    input  logic                   stop_i,
    output logic [COL_W-1:0]       col_o,
    output logic                   valid_o,
    output logic                   last_o
);

    typedef struct packed {
        logic             active;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] cnt;
        logic [COL_W-1:0] mask;
        logic             il;
        logic             page;
    } burst_state_t;

    burst_state_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             at_last;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i (blen_i),
        .mask_o (dec_mask),
        .page_o (dec_page)
    );

    // The final beat of a fixed-length burst is the one where the counter fills the mask
    assign at_last = st_q.active && !st_q.page && (st_q.cnt == st_q.mask);

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.base   = start_col_i;
            st_d.cnt    = '0;
            st_d.mask   = dec_mask;
            st_d.page   = dec_page;
            st_d.il     = wrap_il_i & ~dec_page;
        end else if (st_q.active) begin
            if (stop_i) begin
                st_d.active = 1'b0;
            end else if (adv_i) begin
                if (at_last) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + COL_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    bcg_col_map #(.COL_W(COL_W)) u_map (
        .base_i (st_q.base),
        .cnt_i  (st_q.cnt),
        .mask_i (st_q.mask),
        .il_i   (st_q.il),
        .col_o  (col_o)
    );

    assign valid_o = st_q.active;
    assign last_o  = at_last;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             adv_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o
);

    // R2: a start presents its own column as beat zero
    a_r2_start_col: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    // R6: last only accompanies a valid beat
    a_r6_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R6: advancing past the final beat closes the burst
    a_r6_end: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && adv_i && !start_i) |=> !valid_o);

    // R7: no advance means no movement
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !adv_i && !start_i && !stop_i) |=>
            (valid_o && $stable(col_o) && $stable(last_o)));

    // R9: stop closes an active burst
    a_r9_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && stop_i && !start_i) |=> !valid_o);

    // R11: nothing but a start brings the block out of idle
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i) |=> !valid_o);

    // R3: a non-final advanced beat is followed by another beat
    a_r3_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && adv_i && !last_o && !stop_i && !start_i) |=> valid_o);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_col_gen_bench.sv
`timescale 1ns/1ps
module burst_col_gen_bench;

    localparam int COL_W = 9;
    localparam int ROW   = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       blen_i = '0;
    logic             wrap_il_i = 1'b0;
    logic             adv_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) u_burst_col_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .wrap_il_i(wrap_il_i), .adv_i(adv_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return ROW;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(int st, int k, int len, bit il);
        int m;
        int lo;
        m = len - 1;
        if (len == ROW) return (st + k) % ROW;
        lo = il ? ((st ^ k) & m) : ((st + k) & m);
        return (st & ~m & (ROW - 1)) | lo;
    endfunction

    // Strobe a start; returns at the negedge where beat zero is visible
    task automatic start_burst(int col, int code, bit il, bit with_stop);
        @(negedge clk);
        start_i = 1'b1;
        start_col_i = COL_W'(col);
        blen_i = 3'(code);
        wrap_il_i = il;
        adv_i = 1'b0;
        stop_i = with_stop;
        @(negedge clk);
        start_i = 1'b0;
        stop_i = 1'b0;
    endtask

    task automatic run_burst(int col, int code, bit il);
        int len;
        int beats;
        string tag;
        len = exp_len(code);
        beats = (len == ROW) ? ROW + 3 : len;
        if (len == ROW) tag = "R8";
        else if (code >= 4) tag = "R5";
        else if (il) tag = "R4";
        else tag = "R3";
        start_burst(col, code, il, 1'b0);
        check("R2 first column", int'(col_o), col);
        for (int k = 0; k < beats; k++) begin
            adv_i = 1'b1;
            check({tag, " column"}, int'(col_o), exp_col(col, k, len, il));
            check({tag, " valid"}, int'(valid_o), 1);
            check("R6 last flag", int'(last_o), (len != ROW && k == len - 1) ? 1 : 0);
            @(negedge clk);
        end
        if (len == ROW) begin
            stop_i = 1'b1;
            @(negedge clk);
            stop_i = 1'b0;
            check("R9 page stop", int'(valid_o), 0);
        end else begin
            check("R6 end after last", int'(valid_o), 0);
        end
        adv_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid at reset", int'(valid_o), 0);
        check("R1 last at reset", int'(last_o), 0);
        check("R1 column at reset", int'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: stimulus while idle
        adv_i = 1'b1;
        stop_i = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check("R11 idle stays idle", int'(valid_o), 0);
        end
        adv_i = 1'b0;
        stop_i = 1'b0;

        // R3 R4 R5 R6: sweep lengths, orders and start phases
        for (int code = 0; code < 7; code++) begin
            for (int il = 0; il < 2; il++) begin
                for (int s = 0; s < 32; s++) begin
                    run_burst((s * 37 + 5) % ROW, code, il[0]);
                end
            end
        end

        // R8: full page, wrapping near the row end, both order bits
        run_burst(ROW - 3, 7, 1'b0);
        run_burst(ROW - 3, 7, 1'b1);
        run_burst(0, 7, 1'b1);

        // R7: held advance
        start_burst(100, 3, 1'b0, 1'b0);
        repeat (3) begin
            @(negedge clk);
            check("R7 hold column", int'(col_o), 100);
            check("R7 hold valid", int'(valid_o), 1);
            check("R7 hold last", int'(last_o), 0);
        end
        adv_i = 1'b1;
        @(negedge clk);
        check("R7 resume column", int'(col_o), 101);
        adv_i = 1'b0;

        // R9: stop mid-burst
        start_burst(200, 2, 1'b1, 1'b0);
        adv_i = 1'b1;
        @(negedge clk);
        check("R9 beat before stop", int'(col_o), exp_col(200, 1, 4, 1'b1));
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        adv_i = 1'b0;
        check("R9 stopped", int'(valid_o), 0);
        @(negedge clk);
        check("R9 stays stopped", int'(valid_o), 0);

        // R9: start wins over stop in the same cycle
        start_burst(77, 3, 1'b0, 1'b1);
        check("R9 start beats stop valid", int'(valid_o), 1);
        check("R9 start beats stop column", int'(col_o), 77);

        // R10: restart in mid-burst
        start_burst(40, 3, 1'b0, 1'b0);
        adv_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 before restart", int'(col_o), exp_col(40, 3, 8, 1'b0));
        start_i = 1'b1;
        start_col_i = COL_W'(300);
        blen_i = 3'd1;
        wrap_il_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R10 restart column", int'(col_o), 300);
        check("R10 restart last", int'(last_o), 0);
        @(negedge clk);
        check("R10 second beat", int'(col_o), 301);
        check("R10 second beat last", int'(last_o), 1);
        @(negedge clk);
        check("R10 burst closed", int'(valid_o), 0);
        adv_i = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule